// File: doc/BRIEF.md
# Two-Cycle Interrupt Acknowledge Sequencer

This block sits between a processor core and a 16-bit-data system bus. When the core asks for interrupt service, the block runs a locked pair of interrupt acknowledge bus cycles. In each cycle it drives the address field, the byte enables, the address strobe, the cycle-type code and the bus lock. Each cycle waits for the active-low ready input. A fixed idle gap separates the two cycles.

The first cycle is a dummy: the external interrupt controller uses it to prepare, and whatever is on the data lines when it ends is thrown away. The second cycle returns the interrupt number on the low data byte. The block latches that byte and reports it to the core with a one-clock completion pulse. A request that arrives while a pair is still running is remembered and served once the pair completes. Two pairs never overlap.

Top module: `intack_seq`

## Requirements
- R1: While reset is active, and afterwards until a request is seen, the outputs hold their idle values: ads_n_o=1, lock_n_o=1, done_o=0, ble_n_o=1, bhe_n_o=1, addr_o=0, bus_kind_o=3'b111 and vector_o=0.
- R2: Each of the two bus cycles starts with exactly one clock of ads_n_o low (T1). T2 clocks with ads_n_o high follow, and the cycle ends at the first rising edge in a T2 clock where rdy_n_i is low. rdy_n_i is ignored in T1.
- R3: In both clocks of the first cycle, addr_o (address bits 23..1, with bit index 1 standing for address bit 2) equals 2, which is byte address 4h. During the second cycle addr_o equals 0. During both cycles ble_n_o is 0 and bhe_n_o is 1.
- R4: Exactly four idle clocks lie between the edge that ends the first cycle and the T1 clock of the second. In these clocks ads_n_o=1 and ble_n_o=1, and rdy_n_i has no effect.
- R5: lock_n_o is low from the T1 clock of the first cycle through the last T2 clock of the second, without a break across the gap. It is high in the completion clock.
- R6: Data present when the first cycle ends is discarded. vector_o takes data_i[7:0] at the edge that ends the second cycle, and data_i[15:8] never affects it.
- R7: done_o is high for exactly one clock, the clock right after the second cycle ends, with vector_o valid. vector_o then holds until the next capture.
- R8: bus_kind_o is 3'b000 in every T1 and T2 clock of both cycles and 3'b111 in all other clocks.
- R9: The pipelined next-address input na_n_i has no effect on any output.
- R10: A request pulse seen while a pair is running is kept. The next pair's first T1 then starts two clocks after the done_o clock, with one idle clock between them.
- R11: When req_i is high at a rising edge while the block is idle, the first T1 clock follows immediately.
- R12: Asserting rst_n low at any time forces the R1 idle values at once, discarding any running pair or stored request. Release takes effect after two rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | Core request for an acknowledge pair |
| done_o | output | 1 | One-clock completion pulse |
| vector_o | output | 8 | Captured interrupt number |
| addr_o | output | 23 | Address bits 23..1 |
| ble_n_o | output | 1 | Low byte enable, active low |
| bhe_n_o | output | 1 | High byte enable, active low |
| ads_n_o | output | 1 | Address strobe, active low |
| lock_n_o | output | 1 | Bus lock, active low |
| bus_kind_o | output | 3 | Cycle-type code |
| rdy_n_i | input | 1 | Bus ready, active low |
| na_n_i | input | 1 | Pipelined next-address request, ignored |
| data_i | input | 16 | Bus data |

## Verification
A new core request can land in the same clock as work of the running pair, for example in the middle of the idle gap. It must be stored without disturbing the gap count, the lock or the coming second cycle. The bench pulses req_i inside the gap on chosen sequences. It then expects the gap still to last four clocks and the next first-cycle strobe exactly two clocks after the completion pulse. Ready can also be low in a clock where it must not end a cycle (T1 or the gap). The bench drives rdy_n_i, na_n_i and data_i randomly in those clocks and still demands the exact cycle boundaries and the vector from the second cycle only.

// File: rtl/intack_pkg.sv
package intack_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_A_T1 = 3'd1,
    ST_A_T2 = 3'd2,
    ST_GAP  = 3'd3,
    ST_B_T1 = 3'd4,
    ST_B_T2 = 3'd5,
    ST_DONE = 3'd6
  } seq_state_e;

  localparam logic [2:0] BUS_KIND_ACK  = 3'b000;
  localparam logic [2:0] BUS_KIND_IDLE = 3'b111;
endpackage

// File: rtl/intack_rst_sync.sv
module intack_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/intack_ctrl.sv
module intack_ctrl
  import intack_pkg::*;
#(
  parameter int GAP_STATES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  input  logic       rdy_n_i,
  output seq_state_e state_o,
  output logic       capture_o
);
  localparam int CNT_W = $clog2(GAP_STATES + 1);
  localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_STATES - 1);

  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] gap_q, gap_d;
  logic             gap_en;
  logic             pend_q, pend_d;
  logic             rdy;

  assign rdy = ~rdy_n_i;

  // next-state process
  always_comb begin
    st_d   = st_q;
    gap_d  = gap_q;
    gap_en = 1'b0;
    pend_d = pend_q | req_i;
    unique case (st_q)
      ST_IDLE: begin
        if (pend_q || req_i) begin
          st_d   = ST_A_T1;
          pend_d = 1'b0;
        end
      end
      ST_A_T1: st_d = ST_A_T2;
      ST_A_T2: begin
        if (rdy) begin
          st_d   = ST_GAP;
          gap_d  = '0;
          gap_en = 1'b1;
        end
      end
      ST_GAP: begin
        if (gap_q == GAP_LAST) begin
          st_d = ST_B_T1;
        end else begin
          gap_d  = gap_q + CNT_W'(1);
          gap_en = 1'b1;
        end
      end
      ST_B_T1: st_d = ST_B_T2;
      ST_B_T2: if (rdy) st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      gap_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      if (gap_en) gap_q <= gap_d;
    end
  end

  assign state_o   = st_q;
  assign capture_o = (st_q == ST_B_T2) && rdy;

  // R4
  gap_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_B_T1) |-> ($past(st_q) == ST_GAP && $past(gap_q) == GAP_LAST));

  // R10
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_A_T1) |-> ($past(st_q) == ST_IDLE));
endmodule

// File: rtl/intack_busdrv.sv
module intack_busdrv
  import intack_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int A2_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ble_n_o,
  output logic              bhe_n_o,
  output logic              ads_n_o,
  output logic              lock_n_o,
  output logic [2:0]        bus_kind_o
);
  logic in_cyc;
  logic first_cyc;

  always_comb begin
    in_cyc    = (state_i == ST_A_T1) || (state_i == ST_A_T2) ||
                (state_i == ST_B_T1) || (state_i == ST_B_T2);
    first_cyc = (state_i == ST_A_T1) || (state_i == ST_A_T2);
    addr_o    = '0;
    if (first_cyc) addr_o[A2_BIT] = 1'b1;
    ads_n_o    = !((state_i == ST_A_T1) || (state_i == ST_B_T1));
    lock_n_o   = !(in_cyc || (state_i == ST_GAP));
    ble_n_o    = !in_cyc;
    bhe_n_o    = 1'b1;
    bus_kind_o = in_cyc ? BUS_KIND_ACK : BUS_KIND_IDLE;
  end

  // R2
  ads_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ads_n_o |=> ads_n_o);

  // R5
  lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_n_o) |-> ($past(state_i) == ST_B_T2));
endmodule

// File: rtl/intack_vcap.sv
module intack_vcap #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture_i,
  input  logic [VEC_W-1:0] data_lo_i,
  output logic [VEC_W-1:0] vector_o
);
  logic [VEC_W-1:0] vec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         vec_q <= '0;
    else if (capture_i) vec_q <= data_lo_i;
  end

  assign vector_o = vec_q;

  // R6
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vec_q) |-> $past(capture_i));
endmodule

// File: rtl/intack_seq.sv
module intack_seq
  import intack_pkg::*;
#(
  parameter int ADDR_W     = 23,
  parameter int DATA_W     = 16,
  parameter int VEC_W      = 8,
  parameter int GAP_STATES = 4,
  parameter int SYNC_STG   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  output logic              done_o,
  output logic [VEC_W-1:0]  vector_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ble_n_o,
  output logic              bhe_n_o,
  output logic              ads_n_o,
  output logic              lock_n_o,
  output logic [2:0]        bus_kind_o,
  input  logic              rdy_n_i,
  input  logic              na_n_i,
  input  logic [DATA_W-1:0] data_i
);
  localparam int A2_BIT = 1;

  logic       rst_i_n;
  seq_state_e state;
  logic       capture;
  logic       unused_ignored;

  assign unused_ignored = ^{data_i[DATA_W-1:VEC_W], na_n_i};

  intack_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  intack_ctrl #(.GAP_STATES(GAP_STATES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .req_i     (req_i),
    .rdy_n_i   (rdy_n_i),
    .state_o   (state),
    .capture_o (capture)
  );

  intack_busdrv #(.ADDR_W(ADDR_W), .A2_BIT(A2_BIT)) u_drv (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .state_i    (state),
    .addr_o     (addr_o),
    .ble_n_o    (ble_n_o),
    .bhe_n_o    (bhe_n_o),
    .ads_n_o    (ads_n_o),
    .lock_n_o   (lock_n_o),
    .bus_kind_o (bus_kind_o)
  );

  intack_vcap #(.VEC_W(VEC_W)) u_vcap (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .capture_i (capture),
    .data_lo_i (data_i[VEC_W-1:0]),
    .vector_o  (vector_o)
  );

  assign done_o = (state == ST_DONE);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    done_o |=> !done_o);

  // R5
  done_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    done_o |-> lock_n_o);
endmodule

// File: tb/intack_seq_bench.sv
`timescale 1ns/1ps
module intack_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_i;
  logic        done_o;
  logic [7:0]  vector_o;
  logic [22:0] addr_o;
  logic        ble_n_o, bhe_n_o, ads_n_o, lock_n_o;
  logic [2:0]  bus_kind_o;
  logic        rdy_n_i, na_n_i;
  logic [15:0] data_i;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_vec = 8'h00;

  always #2.5 clk = ~clk;

  intack_seq u_intack_seq (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .done_o(done_o),
    .vector_o(vector_o), .addr_o(addr_o), .ble_n_o(ble_n_o),
    .bhe_n_o(bhe_n_o), .ads_n_o(ads_n_o), .lock_n_o(lock_n_o),
    .bus_kind_o(bus_kind_o), .rdy_n_i(rdy_n_i), .na_n_i(na_n_i),
    .data_i(data_i)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_idle(string tag);
    chk({tag, " R1 ads"},  ads_n_o, 1);
    chk({tag, " R1 lock"}, lock_n_o, 1);
    chk({tag, " R7 done"}, done_o, 0);
    chk({tag, " R1 ble"},  ble_n_o, 1);
    chk({tag, " R1 addr"}, addr_o, 0);
    chk({tag, " R8 kind"}, bus_kind_o, 3'b111);
    chk({tag, " R7 vector hold"}, vector_o, exp_vec);
  endtask

  task automatic chk_t1(string tag, int a);
    chk({tag, " R11/R2 T1 strobe"}, ads_n_o, 0);
    chk({tag, " R5 lock T1"}, lock_n_o, 0);
    chk({tag, " R3 addr T1"}, addr_o, a);
    chk({tag, " R3 ble T1"}, ble_n_o, 0);
    chk({tag, " R3 bhe T1"}, bhe_n_o, 1);
    chk({tag, " R8 kind T1"}, bus_kind_o, 3'b000);
  endtask

  task automatic run_cycle(string tag, int a, int waits, logic [15:0] d);
    chk_t1(tag, a);
    rdy_n_i = 1'($urandom);
    na_n_i  = 1'($urandom);
    data_i  = 16'($urandom);
    for (int i = 0; i <= waits; i++) begin
      @(negedge clk);
      chk({tag, " R2 T2 strobe"}, ads_n_o, 1);
      chk({tag, " R5 lock T2"}, lock_n_o, 0);
      chk({tag, " R3 addr T2"}, addr_o, a);
      chk({tag, " R8 kind T2"}, bus_kind_o, 3'b000);
      chk({tag, " R9/R7 no done"}, done_o, 0);
      rdy_n_i = (i == waits) ? 1'b0 : 1'b1;
      na_n_i  = 1'($urandom);
      data_i  = d;
    end
  endtask

  task automatic do_seq(bit pend, int w1, int w2, logic [15:0] d1,
                        logic [15:0] d2, bit mid);
    if (!pend) req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    run_cycle("first", 2, w1, d1);
    for (int g = 0; g < 4; g++) begin
      @(negedge clk);
      chk("R4 gap strobe", ads_n_o, 1);
      chk("R4 gap ble", ble_n_o, 1);
      chk("R5 gap lock", lock_n_o, 0);
      chk("R8 gap kind", bus_kind_o, 3'b111);
      chk("R6 first data discarded", vector_o, exp_vec);
      rdy_n_i = 1'($urandom);
      na_n_i  = 1'($urandom);
      data_i  = 16'($urandom);
      req_i   = mid && (g == 1);
    end
    @(negedge clk);
    run_cycle("second", 0, w2, d2);
    @(negedge clk);
    rdy_n_i = 1'b1;
    exp_vec = d2[7:0];
    chk("R7 done pulse", done_o, 1);
    chk("R6 vector", vector_o, exp_vec);
    chk("R5 lock off at done", lock_n_o, 1);
    chk("R8 kind done", bus_kind_o, 3'b111);
    @(negedge clk);
    chk_idle("after done R10");
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog R1 actual=hung expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit pending;
    void'($urandom(32'd4242));
    rst_n = 1'b0; req_i = 1'b0; rdy_n_i = 1'b1; na_n_i = 1'b1; data_i = '0;
    repeat (3) @(negedge clk);
    chk_idle("reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_idle("post reset");

    // directed: no wait states, high byte set so it must be dropped (R6)
    do_seq(0, 0, 0, 16'hAB12, 16'hFF5A, 0);
    // directed: request in the gap is kept (R10)
    do_seq(0, 2, 1, 16'h0033, 16'h12C3, 1);
    do_seq(1, 1, 3, 16'h5555, 16'h00E7, 0);

    pending = 0;
    for (int n = 0; n < 30; n++) begin
      bit mid;
      mid = 1'($urandom);
      if (!pending) begin
        repeat ($urandom_range(0, 3)) begin
          na_n_i  = 1'($urandom);
          rdy_n_i = 1'($urandom);
          @(negedge clk);
          chk_idle("idle R9");
        end
      end
      do_seq(pending, $urandom_range(0, 3), $urandom_range(0, 3),
             16'($urandom), 16'($urandom), mid);
      pending = mid;
    end
    if (pending) do_seq(1, 0, 0, 16'h1111, 16'h2299, 0);

    // directed: reset in the middle of a pair (R12)
    req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    exp_vec = 8'h00;
    chk("R12 ads", ads_n_o, 1);
    chk("R12 lock", lock_n_o, 1);
    chk("R12 vector", vector_o, 0);
    chk("R12 done", done_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_idle("R12 released");
    do_seq(0, 1, 0, 16'h00FF, 16'hC03C, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule